// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Controller

This block sits between a synchronous requester and an external asynchronous static RAM of 32K bytes. The requester offers one transaction at a time through a valid/ready handshake. It supplies a 15-bit address, a write flag and a data byte. Read results come back on a registered byte with a one-cycle valid strobe. On the memory side the block drives active-low select, output-enable and write-enable strobes and the address. The data bus is split into an outgoing byte, an incoming byte and a drive-enable.

Every memory timing limit is held as a nanosecond figure for one of two speed grades. Each figure becomes a whole number of clock cycles at elaboration. A write is framed only by the overlap of select and write-enable, with output-enable held inactive the whole time. Before the controller drives write data after a read, it waits until the memory's release window has passed. A standby input lets the current cycle complete and then keeps the memory deselected.

Top module: `asram_ctl`

## Requirements
- R1: During and after reset, with no request, mem_cs_n, mem_oe_n and mem_we_n are 1, mem_dq_oe is 0, rd_valid is 0 and req_ready is 1.
- R2: A read (req_we=0) holds mem_cs_n=0, mem_oe_n=0 and mem_we_n=1 with the drive-enable off. rd_data returns the byte the memory presents at the request address, with rd_valid high for exactly one cycle.
- R3: A write (req_we=1) pulls mem_cs_n and mem_we_n low together for exactly the write-pulse length. mem_oe_n stays 1 throughout. mem_dq_oe is 1 only inside that pulse. Address and outgoing data stay stable across the pulse, and the byte lands at the request address.
- R4: The drive-enable never rises within the release window (in cycles) after the memory last had mem_cs_n=0 and mem_oe_n=0. A write that follows a read directly is therefore delayed by that window less one cycle.
- R5: req_ready falls in the cycle after acceptance and stays low until the memory cycle, including any turnaround, is complete.
- R6: While standby is high, a cycle already under way completes normally. req_ready then stays 0 and mem_cs_n stays 1 until standby is released, after which a pending request is served.
- R7: Each timing figure becomes cycles by rounding ns/period up, with a minimum of 1. The read access length uses the access time (55 or 70 ns). The write pulse uses the largest of pulse width, data setup and address-to-end (40/25/45 or 50/30/60 ns). The release window uses 20 or 30 ns. With an 8 ns clock in the fast grade, rd_valid comes 7 cycles after acceptance, the write pulse lasts 6 cycles and the window is 3 cycles.
- R8: mem_oe_n and mem_we_n are never driven low while mem_cs_n is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| standby | input | 1 | Hold memory deselected after the current cycle |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle strobe for rd_data |
| rd_data | output | 8 | Read result |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | 15 | Memory address |
| mem_dout | output | 8 | Byte driven toward the memory |
| mem_din | input | 8 | Byte returned from the memory |
| mem_dq_oe | output | 1 | Enables the controller's data drive |

## Verification
The bench pairs a memory model with the controller. The model returns a poison byte until the address has been held for the full access time, so an access that is too short reads back wrong data. Writes are run both from idle and straight after a read: the first gives the plain pulse latency, the second shows whether the turnaround gap was inserted. Addresses at both ends of the range, together with all-ones, all-zero and alternating data and an overwrite, separate a correct store from stale or misrouted bytes. A standby raised in the middle of a read shows that the cycle completes and that the pending request is held off until release.

// File: rtl/asram_pkg.sv
package asram_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_READ,
      ST_TURN,
      ST_WRITE
   } asram_state_e;

   // ceil(ns / period), never below one cycle
   function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ps);
      int unsigned c;
      c = (ns * 1000 + clk_ps - 1) / clk_ps;
      if (c == 0) c = 1;
      return c;
   endfunction

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/asram_timing.sv
module asram_timing
   import asram_pkg::*;
#(
   parameter int unsigned CLK_PS     = 8000,
   parameter bit          FAST_GRADE = 1'b1,
   parameter int unsigned CNT_W      = 8
) (
   output logic [CNT_W-1:0] rd_len,
   output logic [CNT_W-1:0] wr_len,
   output logic [CNT_W-1:0] hz_len
);

   localparam int unsigned LIMIT = (1 << CNT_W) - 1;

   generate
      if (FAST_GRADE) begin : g_fast
         localparam int unsigned RD = ns2cyc(55, CLK_PS);
         localparam int unsigned WR = max3(ns2cyc(40, CLK_PS), ns2cyc(25, CLK_PS),
                                           ns2cyc(45, CLK_PS));
         localparam int unsigned HZ = ns2cyc(20, CLK_PS);
         if (RD > LIMIT || WR > LIMIT || HZ > LIMIT) begin : g_bad
            $error("asram_timing: counter width too small for fast grade");
         end
         assign rd_len = CNT_W'(RD);
         assign wr_len = CNT_W'(WR);
         assign hz_len = CNT_W'(HZ);
      end else begin : g_slow
         localparam int unsigned RD = ns2cyc(70, CLK_PS);
         localparam int unsigned WR = max3(ns2cyc(50, CLK_PS), ns2cyc(30, CLK_PS),
                                           ns2cyc(60, CLK_PS));
         localparam int unsigned HZ = ns2cyc(30, CLK_PS);
         if (RD > LIMIT || WR > LIMIT || HZ > LIMIT) begin : g_bad
            $error("asram_timing: counter width too small for slow grade");
         end
         assign rd_len = CNT_W'(RD);
         assign wr_len = CNT_W'(WR);
         assign hz_len = CNT_W'(HZ);
      end
   endgenerate

endmodule

// File: rtl/asram_downctr.sv
module asram_downctr #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/asram_seq.sv
module asram_seq
   import asram_pkg::*;
#(
   parameter int unsigned ADDR_W = 15,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              standby,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              mem_cs_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dout,
   input  logic [DATA_W-1:0] mem_din,
   output logic              mem_dq_oe,
   input  logic [CNT_W-1:0]  rd_len,
   input  logic [CNT_W-1:0]  wr_len,
   input  logic [CNT_W-1:0]  hz_len,
   input  logic              cnt_zero,
   input  logic              gap_zero,
   output logic              cnt_load,
   output logic [CNT_W-1:0]  cnt_val,
   output logic              gap_load,
   output logic [CNT_W-1:0]  gap_val
);

   asram_state_e state_q;
   logic         accept;
   logic         start_wr;

   assign req_ready = (state_q == ST_IDLE) && !standby;
   assign accept    = req_valid && req_ready;
   assign gap_val   = hz_len - 1'b1;
   // a write pulse may open only once the release window has elapsed
   assign start_wr  = gap_zero && (((state_q == ST_IDLE) && accept && req_we) ||
                                   (state_q == ST_TURN));

   always_comb begin
      cnt_load = 1'b0;
      cnt_val  = '0;
      gap_load = 1'b0;
      if (state_q == ST_IDLE && accept && !req_we) begin
         cnt_load = 1'b1;
         cnt_val  = rd_len - 1'b1;
      end else if (start_wr) begin
         cnt_load = 1'b1;
         cnt_val  = wr_len - 1'b1;
      end
      if (state_q == ST_READ && cnt_zero) begin
         gap_load = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         mem_cs_n  <= 1'b1;
         mem_oe_n  <= 1'b1;
         mem_we_n  <= 1'b1;
         mem_dq_oe <= 1'b0;
         mem_addr  <= '0;
         mem_dout  <= '0;
         rd_data   <= '0;
         rd_valid  <= 1'b0;
      end else begin
         rd_valid <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  mem_addr <= req_addr;
                  mem_dout <= req_wdata;
                  if (!req_we) begin
                     state_q  <= ST_READ;
                     mem_cs_n <= 1'b0;
                     mem_oe_n <= 1'b0;
                  end else if (start_wr) begin
                     state_q   <= ST_WRITE;
                     mem_cs_n  <= 1'b0;
                     mem_we_n  <= 1'b0;
                     mem_dq_oe <= 1'b1;
                  end else begin
                     state_q <= ST_TURN;
                  end
               end
            end
            ST_READ: begin
               if (cnt_zero) begin
                  rd_data  <= mem_din;
                  rd_valid <= 1'b1;
                  mem_cs_n <= 1'b1;
                  mem_oe_n <= 1'b1;
                  state_q  <= ST_IDLE;
               end
            end
            ST_TURN: begin
               if (start_wr) begin
                  state_q   <= ST_WRITE;
                  mem_cs_n  <= 1'b0;
                  mem_we_n  <= 1'b0;
                  mem_dq_oe <= 1'b1;
               end
            end
            ST_WRITE: begin
               if (cnt_zero) begin
                  mem_cs_n  <= 1'b1;
                  mem_we_n  <= 1'b1;
                  mem_dq_oe <= 1'b0;
                  state_q   <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/asram_ctl.sv
module asram_ctl #(
   parameter int unsigned ADDR_W     = 15,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned CLK_PS     = 8000,
   parameter bit          FAST_GRADE = 1'b1,
   parameter int unsigned CNT_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              standby,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              mem_cs_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dout,
   input  logic [DATA_W-1:0] mem_din,
   output logic              mem_dq_oe
);

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("asram_ctl: address and data widths must be positive");
      end
      if (CLK_PS < 1) begin : g_bad_clk
         $error("asram_ctl: clock period must be positive");
      end
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt
         $error("asram_ctl: counter width out of range");
      end
   endgenerate

   logic [CNT_W-1:0] rd_len, wr_len, hz_len;
   logic [CNT_W-1:0] cnt_val, gap_val;
   logic             cnt_load, gap_load, cnt_zero, gap_zero;

   asram_timing #(
      .CLK_PS(CLK_PS), .FAST_GRADE(FAST_GRADE), .CNT_W(CNT_W)
   ) u_timing (
      .rd_len(rd_len), .wr_len(wr_len), .hz_len(hz_len)
   );

   // phase counter: access wait or write pulse
   asram_downctr #(.CNT_W(CNT_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val), .zero(cnt_zero)
   );

   // release window after the memory stops driving
   asram_downctr #(.CNT_W(CNT_W)) u_gap (
      .clk(clk), .rst_n(rst_n), .load(gap_load), .load_val(gap_val), .zero(gap_zero)
   );

   asram_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .standby(standby),
      .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data),
      .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
      .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_din(mem_din),
      .mem_dq_oe(mem_dq_oe),
      .rd_len(rd_len), .wr_len(wr_len), .hz_len(hz_len),
      .cnt_zero(cnt_zero), .gap_zero(gap_zero),
      .cnt_load(cnt_load), .cnt_val(cnt_val),
      .gap_load(gap_load), .gap_val(gap_val)
   );

endmodule

// File: rtl/asram_ctl_chk.sv
module asram_ctl_chk
   import asram_pkg::*;
#(
   parameter int unsigned ADDR_W     = 15,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned CLK_PS     = 8000,
   parameter bit          FAST_GRADE = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              standby,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rd_valid,
   input logic              mem_cs_n,
   input logic              mem_oe_n,
   input logic              mem_we_n,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_dout,
   input logic              mem_dq_oe
);

   localparam int unsigned HZ = FAST_GRADE ? ns2cyc(20, CLK_PS) : ns2cyc(30, CLK_PS);

   // cycles since the memory last had select and output-enable both low
   logic [7:0] since_rd;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       since_rd <= 8'hFF;
      else if (!mem_cs_n && !mem_oe_n) since_rd <= 8'd0;
      else if (since_rd != 8'hFF)      since_rd <= since_rd + 8'd1;
   end

   a_r8_strobes_need_select: assert property (@(posedge clk) disable iff (!rst_n)
      mem_cs_n |-> (mem_oe_n && mem_we_n));

   a_r3_oe_off_in_write: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> mem_oe_n);

   a_r3_drive_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (!mem_cs_n && !mem_we_n));

   a_r3_pulse_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dout)));

   a_r4_release_window: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (since_rd >= 8'(HZ)));

   a_r5_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   a_r6_standby_holds: assert property (@(posedge clk) disable iff (!rst_n)
      standby |-> !req_ready);

endmodule

bind asram_ctl asram_ctl_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_PS(CLK_PS), .FAST_GRADE(FAST_GRADE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .standby(standby), .req_valid(req_valid),
   .req_ready(req_ready), .rd_valid(rd_valid), .mem_cs_n(mem_cs_n),
   .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
   .mem_dout(mem_dout), .mem_dq_oe(mem_dq_oe)
);

// File: tb/asram_ctl_tb.sv
`timescale 1ns/1ps
module asram_ctl_tb;

   localparam int ACC_CYC = 7;   // ceil(55/8)
   localparam int PLS_CYC = 6;   // max(ceil(40/8), ceil(25/8), ceil(45/8))
   localparam int HZ_CYC  = 3;   // ceil(20/8)
   localparam int NVEC    = 10;

   // {write, address, data (write byte or expected read), expected latency}
   localparam logic [31:0] VEC [NVEC] = '{
      {1'b1, 15'h7FFF, 8'hA5, 8'd6},
      {1'b1, 15'h0000, 8'h5A, 8'd6},
      {1'b0, 15'h7FFF, 8'hA5, 8'd7},
      {1'b1, 15'h1234, 8'hFF, 8'd8},
      {1'b0, 15'h0000, 8'h5A, 8'd7},
      {1'b0, 15'h1234, 8'hFF, 8'd7},
      {1'b1, 15'h4A5A, 8'h00, 8'd8},
      {1'b0, 15'h4A5A, 8'h00, 8'd7},
      {1'b1, 15'h7FFF, 8'h3C, 8'd8},
      {1'b0, 15'h7FFF, 8'h3C, 8'd7}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        standby = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_we = 1'b0;
   logic [14:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        req_ready, rd_valid, mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [7:0]  rd_data, mem_dout, mem_din;
   logic [14:0] mem_addr;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #4 clk = ~clk;

   asram_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .standby(standby), .req_valid(req_valid),
      .req_ready(req_ready), .req_we(req_we), .req_addr(req_addr),
      .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
      .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
      .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_din(mem_din),
      .mem_dq_oe(mem_dq_oe)
   );

   // ---------------- memory model (64 bytes, indexed by address[5:0]) ----------------
   logic [7:0]  mem [64];
   int          acc = 0;
   int          since_drv = 255;
   int          wr_len = 0;
   logic [14:0] prev_addr = '0;
   logic [14:0] w_addr = '0;
   logic [7:0]  w_data = '0;

   // poison byte until the address has been held for the full access time
   assign mem_din = (!mem_cs_n && !mem_oe_n && acc >= ACC_CYC) ? mem[mem_addr[5:0]] : 8'hEE;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   initial begin
      for (int i = 0; i < 64; i++) mem[i] = 8'h00;
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (!mem_cs_n && !mem_oe_n) begin
            acc = (acc != 0 && mem_addr == prev_addr) ? acc + 1 : 1;
            since_drv = 0;
         end else begin
            acc = 0;
            if (since_drv < 255) since_drv++;
         end
         prev_addr = mem_addr;
         if (mem_cs_n && (!mem_oe_n || !mem_we_n))
            check(0, "R8", "strobe low while deselected", {mem_oe_n, mem_we_n}, 2'b11);
         if (mem_dq_oe && since_drv <= HZ_CYC)
            check(0, "R4", "drive inside release window", since_drv, HZ_CYC + 1);
         if (mem_dq_oe && (mem_cs_n || mem_we_n))
            check(0, "R3", "drive outside write pulse", {mem_cs_n, mem_we_n}, 0);
         if (!mem_cs_n && !mem_we_n) begin
            if (wr_len == 0) begin
               w_addr = mem_addr;
               w_data = mem_dout;
            end else if (mem_addr != w_addr || mem_dout != w_data) begin
               check(0, "R3", "address/data moved in pulse", mem_addr, w_addr);
            end
            if (!mem_oe_n || !mem_dq_oe)
               check(0, "R3", "oe/drive wrong in pulse", {mem_oe_n, mem_dq_oe}, 2'b11);
            wr_len++;
         end else if (wr_len != 0) begin
            check(wr_len == PLS_CYC, "R7", "write pulse length", wr_len, PLS_CYC);
            mem[w_addr[5:0]] = w_data;
            wr_len = 0;
         end
      end
   end

   // ---------------- one transaction ----------------
   task automatic do_op(input bit we, input logic [14:0] a, input logic [7:0] d,
                        input int exp_lat);
      int lat;
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1;
      req_we    = we;
      req_addr  = a;
      req_wdata = d;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      check(!req_ready, "R5", "ready low after acceptance", req_ready, 0);
      lat = 0;
      while (!(we ? req_ready : rd_valid) && lat < 100) begin
         @(negedge clk);
         lat++;
      end
      if (we) begin
         check(lat == exp_lat, "R4", "write latency", lat, exp_lat);
      end else begin
         check(lat == exp_lat, "R7", "read latency", lat, exp_lat);
         check(rd_data == d, "R2", "read data", rd_data, d);
         check(req_ready, "R5", "ready back with read data", req_ready, 1);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int lat;
      bit held;
      repeat (3) @(negedge clk);
      check(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rd_valid, "R1",
            "outputs in reset", {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, rd_valid}, 5'b11100);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rd_valid && req_ready, "R1",
            "idle after reset", {mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, rd_valid, req_ready},
            6'b111001);

      // table walk: R2, R3, R4, R5, R7
      for (int i = 0; i < NVEC; i++) begin
         do_op(VEC[i][31], VEC[i][30:16], VEC[i][15:8], int'(VEC[i][7:0]));
      end

      // single-cycle strobe (R2)
      do_op(1'b0, 15'h0000, 8'h5A, ACC_CYC);
      @(negedge clk);
      check(!rd_valid, "R2", "strobe lasts one cycle", rd_valid, 0);

      // standby raised mid-read (R6)
      req_valid = 1'b1;
      req_we    = 1'b0;
      req_addr  = 15'h7FFF;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      standby   = 1'b1;
      lat = 0;
      while (!rd_valid && lat < 100) begin
         @(negedge clk);
         lat++;
      end
      check(lat == ACC_CYC, "R6", "read finishes under standby", lat, ACC_CYC);
      check(rd_data == 8'h3C, "R6", "read data under standby", rd_data, 8'h3C);
      req_valid = 1'b1;
      req_we    = 1'b1;
      req_addr  = 15'h0000;
      req_wdata = 8'h99;
      held = 1'b1;
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         if (req_ready || !mem_cs_n) held = 1'b0;
      end
      check(held, "R6", "request held off while standby", held, 1);
      standby = 1'b0;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      while (!req_ready) @(negedge clk);
      do_op(1'b0, 15'h0000, 8'h99, ACC_CYC);

      repeat (5) @(negedge clk);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule